// File: doc/BRIEF.md
# Six-Channel Shared-Timebase PWM with Complementary Dead-Time Pair

This block makes six pulse-width-modulated waveforms from a single 16-bit up-counter. The counter advances once per PWM clock tick, which arrives as a clock-enable on the system clock. It starts at zero, climbs to the programmed period value and then wraps. Each channel compares the counter with its own 16-bit duty value. The channel output is high while the count is below the duty.

Channel 0 drives a positive and a negative output. A 2-bit mode input picks what those two outputs carry. In the complementary mode, the negative output is the inverse of the channel waveform, and a dead-time unit delays every rising edge on either output by 0 to 15 PWM ticks. As a result the two outputs are never high together. Period and duty values are held in working copies. These copies follow the inputs while the block is disabled and are refreshed only at the period wrap while it runs.

A period-end strobe marks each wrap, so surrounding logic can update the period and duty inputs in step with the waveform.

Top module: `pwm6_deadtime`

## Requirements
- R1: While enabled, the counter advances on each cycle with `tickEn` high and wraps from the period value to 0, so one PWM period lasts period+1 ticks. `periodEnd` is high for exactly the cycles where `tickEn` is high and the count equals the period.
- R2: Channel k (1 to 5) on `chOut[k-1]` is high exactly when the count is below its duty (`dutyIn[16k+15:16k]`). A duty of 0 therefore keeps it low, and a duty above the period keeps it high.
- R3: Changes to `periodIn` or `dutyIn` made while running have no effect until the next wrap. From the wrap onward the new values apply.
- R4: On cycles with `tickEn` low, the counter and the dead-time delay do not advance.
- R5: With `enable` low, every output is low and the counter is held at 0. After enabling, the first period starts at count 0 with the current input values.
- R6: `modeSel` encodings: 0 gives `pOut` = channel-0 waveform and `nOut` low; 1 gives `nOut` = channel-0 waveform and `pOut` low; 3 gives both outputs equal to the channel-0 waveform. None of these three modes adds a delay.
- R7: In mode 2, `pOut` follows the channel-0 waveform and `nOut` follows its inverse. Each rising edge is delayed by `deadTime` ticks, and each falling edge is immediate.
- R8: In mode 2, a high interval on either side that is no longer than `deadTime` ticks is suppressed entirely. `pOut` and `nOut` are never high in the same cycle.
- R9: In mode 2 with `deadTime` of 0, `nOut` is the exact inverse of `pOut` while enabled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| tickEn | input | 1 | PWM clock enable; one tick per high cycle |
| enable | input | 1 | Global run enable |
| periodIn | input | 16 | Period value (last count before wrap) |
| dutyIn | input | 96 | Six duty values, channel k in bits 16k+15:16k |
| modeSel | input | 2 | Channel-0 output mode |
| deadTime | input | 4 | Rising-edge delay in ticks for mode 2 |
| pOut | output | 1 | Channel-0 positive output |
| nOut | output | 1 | Channel-0 negative output |
| chOut | output | 5 | Channels 1 to 5, channel k on bit k-1 |
| periodEnd | output | 1 | High on the tick that wraps the counter |

## Verification
The hardest cases to reach are suppressed pulses: a duty that is just below the dead time, or a low gap at the end of the period that is no longer than it. Each of these gives only a short window. The bench reaches them with a sweep over small periods (0 to 4), every duty from 0 to period+2, and dead times 0 to 3, under both a steady and a sparse tick pattern. The expected level of each output is computed from the tick index alone. The deferred-load case is forced by changing period and duties mid-period and checking that the old waveform continues until the wrap.

// File: rtl/pwm6_pkg.sv
package pwm6_pkg;

  // Strobes passed from the timebase control to the channel datapath.
  typedef struct packed {
    logic run;   // block enabled
    logic tick;  // counter advances this cycle
    logic wrap;  // counter at period on a tick
    logic load;  // working copies take the inputs at this edge
  } pwmStrobes_t;

  typedef enum logic [1:0] {
    MODE_P_ONLY = 2'd0,
    MODE_N_ONLY = 2'd1,
    MODE_COMP   = 2'd2,
    MODE_SAME   = 2'd3
  } ch0Mode_e;

endpackage

// File: rtl/pwm6_ctrl.sv
module pwm6_ctrl
  import pwm6_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic             tickEn,
  input  logic [WIDTH-1:0] periodIn,
  output logic [WIDTH-1:0] count,
  output pwmStrobes_t      strobes,
  output logic             periodEnd
);

  logic [WIDTH-1:0] activePeriod;
  logic             atTop;

  assign atTop = (count == activePeriod);

  always_comb begin
    strobes.run  = enable;
    strobes.tick = enable && tickEn;
    strobes.wrap = enable && tickEn && atTop;
    strobes.load = !enable || (tickEn && atTop);
  end

  assign periodEnd = strobes.wrap;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      activePeriod <= '0;
    end else if (strobes.load) begin
      activePeriod <= periodIn;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count <= '0;
    end else if (!enable || strobes.wrap) begin
      count <= '0;
    end else if (strobes.tick) begin
      count <= count + 1'b1;
    end
  end

  // R1: the count never passes the period it is working toward
  p_count_bounded_r1: assert property (@(posedge clk) disable iff (!rstN)
    enable |-> (count <= activePeriod));

  // R1: a wrap always restarts from zero
  p_wrap_zero_r1: assert property (@(posedge clk) disable iff (!rstN)
    strobes.wrap |=> (count == '0));

  // R4: no tick, no movement
  p_hold_no_tick_r4: assert property (@(posedge clk) disable iff (!rstN)
    (enable && !tickEn) |=> (!enable || $stable(count)));

  // R5: disabled keeps the counter at zero
  p_disabled_zero_r5: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> (count == '0));

  // R3: running period copy only changes at a wrap
  p_period_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    (enable && !strobes.wrap) |=> $stable(activePeriod));

endmodule

// File: rtl/pwm6_deadband.sv
module pwm6_deadband #(
  parameter int DT_WIDTH = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                tick,
  input  logic                src,
  input  logic                bypass,
  input  logic [DT_WIDTH-1:0] deadTime,
  output logic                out
);

  logic [DT_WIDTH-1:0] heldTicks;

  // Counts ticks since src rose; saturates at the dead time.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      heldTicks <= '0;
    end else if (!src) begin
      heldTicks <= '0;
    end else if (tick && (heldTicks < deadTime)) begin
      heldTicks <= heldTicks + 1'b1;
    end
  end

  assign out = src && (bypass || (heldTicks >= deadTime));

  // R7: falling edge follows the source at once
  p_fall_immediate_r7: assert property (@(posedge clk) disable iff (!rstN)
    !src |-> !out);

  // R7: with a nonzero delay the output never rises together with its source
  p_no_early_rise_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!bypass && (deadTime != '0) && $rose(out)) |-> $past(src));

endmodule

// File: rtl/pwm6_datapath.sv
module pwm6_datapath
  import pwm6_pkg::*;
#(
  parameter int WIDTH    = 16,
  parameter int CHANNELS = 6,
  parameter int DT_WIDTH = 4
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  pwmStrobes_t               strobes,
  input  logic [WIDTH-1:0]          count,
  input  logic [CHANNELS*WIDTH-1:0] dutyIn,
  input  logic [1:0]                modeSel,
  input  logic [DT_WIDTH-1:0]       deadTime,
  output logic                      pOut,
  output logic                      nOut,
  output logic [CHANNELS-2:0]       chOut
);

  localparam int SIDES = 2;

  logic [CHANNELS-1:0][WIDTH-1:0] activeDuty;
  logic [CHANNELS-1:0]            rawWave;
  logic [SIDES-1:0]               sideSrc;
  logic [SIDES-1:0]               sideOut;
  logic                           sideBypass;

  for (genvar g = 0; g < CHANNELS; g++) begin : g_chan
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        activeDuty[g] <= '0;
      end else if (strobes.load) begin
        activeDuty[g] <= dutyIn[g*WIDTH +: WIDTH];
      end
    end

    assign rawWave[g] = strobes.run && (count < activeDuty[g]);

    if (g > 0) begin : g_plain
      assign chOut[g-1] = rawWave[g];
    end
  end

  // Channel-0 routing: side 0 is the positive output, side 1 the negative.
  always_comb begin
    sideSrc    = '0;
    sideBypass = 1'b1;
    case (ch0Mode_e'(modeSel))
      MODE_P_ONLY: sideSrc[0] = rawWave[0];
      MODE_N_ONLY: sideSrc[1] = rawWave[0];
      MODE_COMP: begin
        sideSrc[0] = rawWave[0];
        sideSrc[1] = strobes.run && !rawWave[0];
        sideBypass = 1'b0;
      end
      default: begin
        sideSrc[0] = rawWave[0];
        sideSrc[1] = rawWave[0];
      end
    endcase
  end

  for (genvar s = 0; s < SIDES; s++) begin : g_side
    pwm6_deadband #(.DT_WIDTH(DT_WIDTH)) u_band (
      .clk      (clk),
      .rstN     (rstN),
      .tick     (strobes.tick),
      .src      (sideSrc[s]),
      .bypass   (sideBypass),
      .deadTime (deadTime),
      .out      (sideOut[s])
    );
  end

  assign pOut = sideOut[0];
  assign nOut = sideOut[1];

  // R8: the complementary pair never overlaps
  p_pair_exclusive_r8: assert property (@(posedge clk) disable iff (!rstN)
    (modeSel == MODE_COMP) |-> !(pOut && nOut));

  // R5: disabled means every output is low
  p_disabled_low_r5: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.run |-> (!pOut && !nOut && (chOut == '0)));

  // R7: with a delay, a positive rise is preceded by a cycle with both low
  p_gap_before_p_r7: assert property (@(posedge clk) disable iff (!rstN)
    ((modeSel == MODE_COMP) && (deadTime != '0) && $rose(pOut)) |-> !$past(nOut));

  // R3: working duty copies hold between wraps
  p_duty_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.run && !strobes.wrap) |=> $stable(activeDuty));

endmodule

// File: rtl/pwm6_deadtime.sv
module pwm6_deadtime
  import pwm6_pkg::*;
#(
  parameter int WIDTH    = 16,
  parameter int CHANNELS = 6,
  parameter int DT_WIDTH = 4
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      tickEn,
  input  logic                      enable,
  input  logic [WIDTH-1:0]          periodIn,
  input  logic [CHANNELS*WIDTH-1:0] dutyIn,
  input  logic [1:0]                modeSel,
  input  logic [DT_WIDTH-1:0]       deadTime,
  output logic                      pOut,
  output logic                      nOut,
  output logic [CHANNELS-2:0]       chOut,
  output logic                      periodEnd
);

  pwmStrobes_t      strobes;
  logic [WIDTH-1:0] count;

  pwm6_ctrl #(.WIDTH(WIDTH)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .enable    (enable),
    .tickEn    (tickEn),
    .periodIn  (periodIn),
    .count     (count),
    .strobes   (strobes),
    .periodEnd (periodEnd)
  );

  pwm6_datapath #(
    .WIDTH    (WIDTH),
    .CHANNELS (CHANNELS),
    .DT_WIDTH (DT_WIDTH)
  ) u_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .count    (count),
    .dutyIn   (dutyIn),
    .modeSel  (modeSel),
    .deadTime (deadTime),
    .pOut     (pOut),
    .nOut     (nOut),
    .chOut    (chOut)
  );

endmodule

// File: tb/pwm6_deadtime_bench.sv
`timescale 1ns/1ps
module pwm6_deadtime_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tickEn = 1'b0;
  logic        enable = 1'b0;
  logic [15:0] periodIn = '0;
  logic [95:0] dutyIn = '0;
  logic [1:0]  modeSel = '0;
  logic [3:0]  deadTime = '0;
  logic        pOut, nOut, periodEnd;
  logic [4:0]  chOut;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  pwm6_deadtime u_pwm6_deadtime (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .enable(enable),
    .periodIn(periodIn), .dutyIn(dutyIn), .modeSel(modeSel),
    .deadTime(deadTime), .pOut(pOut), .nOut(nOut), .chOut(chOut),
    .periodEnd(periodEnd)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // One enabled run with fixed settings, checked every cycle.
  task automatic runCase(input int per, input int d0, input int dt,
                         input int mode, input int tickDiv);
    int d[6];
    int k;
    int nTicks;
    int cyc;
    bit ticked;
    int c, expP, expN, raw;
    string tag;
    d[0] = d0;
    for (int i = 1; i < 6; i++) d[i] = (d0 + i) % (per + 3);
    @(negedge clk);
    enable   = 1'b0;
    tickEn   = 1'b0;
    periodIn = 16'(per);
    for (int i = 0; i < 6; i++) dutyIn[i*16 +: 16] = 16'(d[i]);
    modeSel  = 2'(mode);
    deadTime = 4'(dt);
    @(negedge clk);
    enable = 1'b1;
    k = 0;
    cyc = 0;
    nTicks = 2 * (per + 1) + dt + 2;
    while (k < nTicks) begin
      tickEn = ((cyc % tickDiv) == 0);
      #1;
      c = k % (per + 1);
      for (int i = 1; i < 6; i++)
        chk($sformatf("R2 ch%0d k=%0d", i, k), int'(chOut[i-1]), int'(c < d[i]));
      chk(tickDiv > 1 ? "R4 periodEnd" : "R1 periodEnd", int'(periodEnd),
          int'(tickEn && (c == per)));
      raw = int'(c < d0);
      if (mode == 2) begin
        if (d0 == 0) begin
          expP = 0; expN = int'(k >= dt);
        end else if (d0 > per) begin
          expP = int'(k >= dt); expN = 0;
        end else begin
          expP = int'((c >= dt) && (c < d0));
          expN = int'(c >= d0 + dt);
        end
        if (dt == 0) tag = "R9";
        else if ((d0 > 0 && d0 <= per && d0 <= dt) ||
                 (d0 > 0 && d0 <= per && per - d0 + 1 <= dt)) tag = "R8";
        else tag = "R7";
      end else begin
        tag  = "R6";
        expP = (mode == 1) ? 0 : raw;
        expN = (mode == 0) ? 0 : raw;
      end
      chk($sformatf("%s pOut m%0d per=%0d d=%0d dt=%0d k=%0d", tag, mode, per, d0, dt, k),
          int'(pOut), expP);
      chk($sformatf("%s nOut m%0d per=%0d d=%0d dt=%0d k=%0d", tag, mode, per, d0, dt, k),
          int'(nOut), expN);
      ticked = tickEn;
      @(negedge clk);
      if (ticked) k++;
      cyc++;
    end
    enable = 1'b0;
    tickEn = 1'b1;
    #1;
    chk("R5 disabled outputs", int'({pOut, nOut, chOut, periodEnd}), 0);
  endtask

  // Mid-period update: old settings last until the wrap.
  task automatic shadowCase();
    int c, pe, du;
    @(negedge clk);
    enable = 1'b0; tickEn = 1'b1;
    periodIn = 16'd5; modeSel = 2'd0; deadTime = 4'd3;
    for (int i = 0; i < 6; i++) dutyIn[i*16 +: 16] = 16'd4;
    @(negedge clk);
    enable = 1'b1;
    for (int k = 0; k < 15; k++) begin
      #1;
      if (k < 6) begin c = k; pe = 5; du = 4; end
      else begin c = (k - 6) % 3; pe = 2; du = 1; end
      chk($sformatf("R3 ch1 k=%0d", k), int'(chOut[0]), int'(c < du));
      chk($sformatf("R3 pOut k=%0d", k), int'(pOut), int'(c < du));
      chk($sformatf("R3 periodEnd k=%0d", k), int'(periodEnd), int'(c == pe));
      if (k == 2) begin
        periodIn = 16'd2;
        for (int i = 0; i < 6; i++) dutyIn[i*16 +: 16] = 16'd1;
      end
      @(negedge clk);
    end
    enable = 1'b0;
  endtask

  initial begin
    #(4 * 100000);
    errors++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    #1;
    chk("R5 reset outputs", int'({pOut, nOut, chOut, periodEnd}), 0);
    for (int per = 0; per <= 4; per++)
      for (int d0 = 0; d0 <= per + 2; d0++)
        for (int dt = 0; dt <= 3; dt++)
          for (int mode = 0; mode < 4; mode++)
            runCase(per, d0, dt, mode, 1);
    for (int per = 1; per <= 4; per++)
      for (int d0 = 0; d0 <= per + 1; d0++)
        for (int dt = 0; dt <= 3; dt++)
          runCase(per, d0, dt, 2, 3);
    shadowCase();
    summary();
  end

endmodule